// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it may take one operation code, the accumulator value, a second operand and the carry held in its own flag register. It returns a result byte and a write strobe for the destination, and it updates a status register. That register holds sign, zero, even parity, carry and a carry between nibbles for decimal correction. A separate 16-bit adder adds a register pair to the pointer pair and returns the sum. That operation changes only the carry. Two carry-only operations set the carry or invert it.

The flag register can be loaded as a whole byte and is always visible as one byte. The bit positions are fixed, and the three unused positions read as constants. The surrounding sequencer routes the result to the accumulator or to another register. For compare, carry-only operations and the wide add, it receives no write strobe.

Top module: `acc_alu8`

## Requirements
- R1: Opcodes 0 (add) and 1 (add with carry) return A+B (+carry for 1) modulo 256. Carry (flag bit 0) takes the carry out of bit 7. The nibble carry (flag bit 4) takes the carry out of bit 3.
- R2: Opcodes 2 (subtract) and 3 (subtract with borrow) return A−B (−carry for 3) modulo 256. Carry is set when a borrow is needed. The nibble carry is set when the low nibble needs a borrow.
- R3: After every opcode from 0 to 9, three flags follow the result byte. Sign (flag bit 7) copies result bit 7. Zero (flag bit 6) is set for a zero result. Parity (flag bit 2) is set when the result has an even number of one bits.
- R4: Opcodes 4 (AND), 5 (XOR) and 6 (OR) return the bitwise result of A and B and clear both carry and nibble carry.
- R5: Opcode 7 (compare) sets the flags exactly as subtract does, and its write strobe stays low.
- R6: Opcodes 8 (increment) and 9 (decrement) act on the operand input, not on A. They update sign, zero, parity and nibble carry: the nibble carry is set when the low nibble wraps. Carry is left unchanged.
- R7: Opcode 10 sets carry to 1 and opcode 11 inverts carry. Neither changes any other flag.
- R8: Opcode 12 presents pointer+pair modulo 65536 on the wide output and sets carry to bit 16 of the sum. All other flags are left unchanged. A pointer added to itself gives the pointer shifted left by one.
- R9: The flag byte reads S,Z,0,AC,0,P,1,CY from bit 7 down to bit 0, and it resets to 0x02. Bits 5 and 3 always read 0 and bit 1 always reads 1.
- R10: A group write replaces the flags from the write-data byte, but the constant bits stay as R9 states. When a group write and an operation fall in the same cycle, the group write sets the flags. The operation still drives its result, computed with the carry held before that edge.
- R11: The write strobe is high only for a valid opcode 0–6, 8 or 9.
- R12: Opcodes 13–15 and idle cycles leave the flags unchanged and keep the write strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation select |
| accIn | input | 8 | Accumulator operand A |
| operand | input | 8 | Second operand B, or the target of increment and decrement |
| hlIn | input | 16 | Pointer pair for the wide add |
| pairIn | input | 16 | Register pair added to the pointer |
| flagWrEn | input | 1 | Group write of the flag byte |
| flagWrData | input | 8 | Flag byte to load |
| result | output | 8 | Result byte |
| resultWe | output | 1 | Destination write strobe |
| wideSum | output | 16 | Wide-add sum |
| flags | output | 8 | Flag byte |

## Verification
Two functions can fall in the same edge: the group load of the flag byte and the flag update from an operation. The bench triggers this by asserting a group write in the same cycle as an add that would set different flags. It then checks that the flags match the written byte, and that the result driven in that cycle used the carry held before the edge. The sweeps also load random flag bytes before every operation. A flag that an operation must leave alone is therefore checked against a known, non-trivial value.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

  localparam logic [3:0] OPC_ADD = 4'd0;
  localparam logic [3:0] OPC_ADC = 4'd1;
  localparam logic [3:0] OPC_SUB = 4'd2;
  localparam logic [3:0] OPC_SBB = 4'd3;
  localparam logic [3:0] OPC_AND = 4'd4;
  localparam logic [3:0] OPC_XOR = 4'd5;
  localparam logic [3:0] OPC_OR  = 4'd6;
  localparam logic [3:0] OPC_CMP = 4'd7;
  localparam logic [3:0] OPC_INC = 4'd8;
  localparam logic [3:0] OPC_DEC = 4'd9;
  localparam logic [3:0] OPC_STC = 4'd10;
  localparam logic [3:0] OPC_CMC = 4'd11;
  localparam logic [3:0] OPC_DAD = 4'd12;

  localparam int FLAG_W  = 8;
  localparam int BIT_CY  = 0;
  localparam int BIT_ONE = 1;
  localparam int BIT_P   = 2;
  localparam int BIT_Z3  = 3;
  localparam int BIT_AC  = 4;
  localparam int BIT_Z5  = 5;
  localparam int BIT_Z   = 6;
  localparam int BIT_S   = 7;
  localparam logic [FLAG_W-1:0] FLAG_RESET = 8'h02;

  typedef enum logic [1:0] {B_PASS, B_ZERO, B_ONES} bSel_e;
  typedef enum logic [1:0] {R_ARITH, R_AND, R_XOR, R_OR} rSel_e;

  typedef struct packed {
    logic  aFromOperand;
    bSel_e bSel;
    logic  invertB;
    logic  subMode;
    logic  useCarry;
    logic  forceCin;
    rSel_e rSel;
    logic  updSzpAc;
    logic  updCarry;
    logic  writeRes;
    logic  setCarry;
    logic  cmcCarry;
    logic  wideAdd;
  } aluStrobe_t;

endpackage

// File: rtl/acc_alu8_ctrl.sv
module acc_alu8_ctrl
  import acc_alu8_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output aluStrobe_t stb
);

  always_comb begin
    stb = '0;
    stb.bSel = B_PASS;
    stb.rSel = R_ARITH;
    if (opValid) begin
      case (opCode)
        OPC_ADD, OPC_ADC: begin
          stb.useCarry = (opCode == OPC_ADC);
          stb.updSzpAc = 1'b1;
          stb.updCarry = 1'b1;
          stb.writeRes = 1'b1;
        end
        OPC_SUB, OPC_SBB, OPC_CMP: begin
          stb.invertB  = 1'b1;
          stb.subMode  = 1'b1;
          stb.forceCin = 1'b1;
          stb.useCarry = (opCode == OPC_SBB);
          stb.updSzpAc = 1'b1;
          stb.updCarry = 1'b1;
          stb.writeRes = (opCode != OPC_CMP);
        end
        OPC_AND, OPC_XOR, OPC_OR: begin
          stb.rSel     = (opCode == OPC_AND) ? R_AND :
                         (opCode == OPC_XOR) ? R_XOR : R_OR;
          stb.updSzpAc = 1'b1;
          stb.updCarry = 1'b1;
          stb.writeRes = 1'b1;
        end
        OPC_INC: begin
          stb.aFromOperand = 1'b1;
          stb.bSel         = B_ZERO;
          stb.forceCin     = 1'b1;
          stb.updSzpAc     = 1'b1;
          stb.writeRes     = 1'b1;
        end
        OPC_DEC: begin
          stb.aFromOperand = 1'b1;
          stb.bSel         = B_ONES;
          stb.subMode      = 1'b1;
          stb.updSzpAc     = 1'b1;
          stb.writeRes     = 1'b1;
        end
        OPC_STC: stb.setCarry = 1'b1;
        OPC_CMC: stb.cmcCarry = 1'b1;
        OPC_DAD: stb.wideAdd  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu8_dp.sv
module acc_alu8_dp
  import acc_alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  aluStrobe_t          stb,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [DATA_W-1:0]   operand,
  input  logic [2*DATA_W-1:0] hlIn,
  input  logic [2*DATA_W-1:0] pairIn,
  input  logic                flagWrEn,
  input  logic [FLAG_W-1:0]   flagWrData,
  output logic [DATA_W-1:0]   result,
  output logic                resultWe,
  output logic [2*DATA_W-1:0] wideSum,
  output logic [FLAG_W-1:0]   flags
);

  localparam int HALF_W = DATA_W / 2;
  localparam int WIDE_W = 2 * DATA_W;

  logic [FLAG_W-1:0] flagsQ, flagsD;
  logic [DATA_W-1:0] opA, bRaw, opB, res;
  logic              cin, carryHeld;
  logic [DATA_W:0]   sumFull;
  logic [HALF_W:0]   loFull;
  logic [WIDE_W:0]   wideFull;
  logic              arithCy, arithAc, resCy, resAc, parityEven;

  assign carryHeld = flagsQ[BIT_CY];

  always_comb begin
    opA = stb.aFromOperand ? operand : accIn;
    case (stb.bSel)
      B_ZERO:  bRaw = '0;
      B_ONES:  bRaw = '1;
      default: bRaw = operand;
    endcase
    opB = stb.invertB ? ~bRaw : bRaw;
    cin = stb.useCarry ? (carryHeld ^ stb.subMode) : stb.forceCin;
  end

  assign sumFull = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, cin};
  assign loFull  = {1'b0, opA[HALF_W-1:0]} + {1'b0, opB[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
  assign arithCy = sumFull[DATA_W] ^ stb.subMode;
  assign arithAc = loFull[HALF_W] ^ stb.subMode;

  always_comb begin
    resCy = 1'b0;
    resAc = 1'b0;
    case (stb.rSel)
      R_AND:   res = accIn & operand;
      R_XOR:   res = accIn ^ operand;
      R_OR:    res = accIn | operand;
      default: begin
        res   = sumFull[DATA_W-1:0];
        resCy = arithCy;
        resAc = arithAc;
      end
    endcase
  end

  assign parityEven = ~^res;
  assign wideFull   = {1'b0, hlIn} + {1'b0, pairIn};

  always_comb begin
    flagsD = flagsQ;
    if (stb.updSzpAc) begin
      flagsD[BIT_S]  = res[DATA_W-1];
      flagsD[BIT_Z]  = (res == '0);
      flagsD[BIT_AC] = resAc;
      flagsD[BIT_P]  = parityEven;
    end
    if (stb.updCarry) flagsD[BIT_CY] = resCy;
    if (stb.setCarry) flagsD[BIT_CY] = 1'b1;
    if (stb.cmcCarry) flagsD[BIT_CY] = ~carryHeld;
    if (stb.wideAdd)  flagsD[BIT_CY] = wideFull[WIDE_W];
    if (flagWrEn)     flagsD = flagWrData;
    flagsD[BIT_ONE] = 1'b1;
    flagsD[BIT_Z3]  = 1'b0;
    flagsD[BIT_Z5]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= FLAG_RESET;
    else       flagsQ <= flagsD;
  end

  assign result   = res;
  assign resultWe = stb.writeRes;
  assign wideSum  = wideFull[WIDE_W-1:0];
  assign flags    = flagsQ;

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [3:0]          opCode,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [DATA_W-1:0]   operand,
  input  logic [2*DATA_W-1:0] hlIn,
  input  logic [2*DATA_W-1:0] pairIn,
  input  logic                flagWrEn,
  input  logic [7:0]          flagWrData,
  output logic [DATA_W-1:0]   result,
  output logic                resultWe,
  output logic [2*DATA_W-1:0] wideSum,
  output logic [7:0]          flags
);

  aluStrobe_t stb;

  acc_alu8_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .stb     (stb)
  );

  acc_alu8_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .accIn      (accIn),
    .operand    (operand),
    .hlIn       (hlIn),
    .pairIn     (pairIn),
    .flagWrEn   (flagWrEn),
    .flagWrData (flagWrData),
    .result     (result),
    .resultWe   (resultWe),
    .wideSum    (wideSum),
    .flags      (flags)
  );

endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk
  import acc_alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] result,
  input logic              resultWe,
  input logic              flagWrEn,
  input logic [7:0]        flagWrData,
  input logic [7:0]        flags
);

  assert_filler_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    flags[BIT_ONE] && !flags[BIT_Z3] && !flags[BIT_Z5]);

  assert_group_write_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |=> (flags == (($past(flagWrData) & 8'hD5) | 8'h02)));

  assert_stc_only_carry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OPC_STC && !flagWrEn) |=>
      (flags[BIT_CY] && flags[7:1] == $past(flags[7:1])));

  assert_cmc_inverts_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OPC_CMC && !flagWrEn) |=>
      (flags[BIT_CY] == !$past(flags[BIT_CY]) && flags[7:1] == $past(flags[7:1])));

  assert_dad_keeps_others_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OPC_DAD && !flagWrEn) |=> $stable(flags[7:1]));

  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OPC_CMP) |-> !resultWe);

  assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !resultWe);

  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode <= OPC_DEC && !flagWrEn) |=>
      (flags[BIT_Z] == ($past(result) == '0)));

  assert_unused_op_R12: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode > OPC_DAD && !flagWrEn) |=> $stable(flags));

endmodule

bind acc_alu8 acc_alu8_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .opCode     (opCode),
  .result     (result),
  .resultWe   (resultWe),
  .flagWrEn   (flagWrEn),
  .flagWrData (flagWrData),
  .flags      (flags)
);

// File: tb/sim_acc_alu8.sv
module sim_acc_alu8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [3:0]  opCode;
  logic [7:0]  accIn, operand;
  logic [15:0] hlIn, pairIn;
  logic        flagWrEn;
  logic [7:0]  flagWrData;
  logic [7:0]  result;
  logic        resultWe;
  logic [15:0] wideSum;
  logic [7:0]  flags;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  acc_alu8 u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .operand(operand), .hlIn(hlIn), .pairIn(pairIn),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .result(result), .resultWe(resultWe), .wideSum(wideSum), .flags(flags)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input int op);
    case (op)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4, 5, 6: return "R4";
      7:       return "R5";
      8, 9:    return "R6";
      10, 11:  return "R7";
      12:      return "R8";
      default: return "R12";
    endcase
  endfunction

  function automatic bit evenOnes(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  function automatic int packFlags(input bit s, input bit z, input bit ac, input bit p, input bit cy);
    return (int'(s) << 7) | (int'(z) << 6) | (int'(ac) << 4) | (int'(p) << 2) | 2 | int'(cy);
  endfunction

  // reference model: writes r, we, fl from the requirements
  task automatic model(input int op, input int a, input int b, input int hl, input int pr,
                       input int pre, output int r, output int we, output int fl);
    int  c, d;
    bit  cy, ac, upd;
    cy  = pre[0];
    ac  = 0;
    upd = 1;
    r   = 0;
    we  = (op <= 6 || op == 8 || op == 9);
    case (op)
      0, 1: begin
        c = (op == 1) ? int'(pre[0]) : 0;
        d = a + b + c; r = d & 255; cy = d > 255;
        ac = ((a & 15) + (b & 15) + c) > 15;
      end
      2, 3, 7: begin
        c = (op == 3) ? int'(pre[0]) : 0;
        d = a - b - c; r = d & 255; cy = d < 0;
        ac = ((a & 15) - (b & 15) - c) < 0;
      end
      4: begin r = a & b; cy = 0; end
      5: begin r = a ^ b; cy = 0; end
      6: begin r = a | b; cy = 0; end
      8: begin r = (b + 1) & 255; ac = (b & 15) == 15; end
      9: begin r = (b + 255) & 255; ac = (b & 15) == 0; end
      default: upd = 0;
    endcase
    if (upd) fl = packFlags(r[7], r == 0, ac, evenOnes(r), cy);
    else begin
      fl = pre;
      if (op == 10) fl = fl | 1;
      if (op == 11) fl = fl ^ 1;
      if (op == 12) fl = (fl & 8'hFE) | (((hl + pr) >> 16) & 1);
    end
  endtask

  // at a falling edge: load preset flags, apply op next cycle, check
  task automatic runVec(input int op, input int a, input int b, input int hl, input int pr, input int pre);
    int preFix, r, we, fl;
    preFix = (pre & 8'hD5) | 8'h02;
    flagWrEn = 1'b1; flagWrData = pre[7:0]; opValid = 1'b0;
    @(negedge clk);
    check("R10", flags, preFix);
    flagWrEn = 1'b0; opValid = 1'b1; opCode = op[3:0];
    accIn = a[7:0]; operand = b[7:0]; hlIn = hl[15:0]; pairIn = pr[15:0];
    model(op, a, b, hl, pr, preFix, r, we, fl);
    #2;
    check("R11", resultWe, we);
    if (we != 0 || op == 7) check(reqOf(op), result, r);
    if (op == 12) check("R8", wideSum, (hl + pr) & 16'hFFFF);
    @(negedge clk);
    opValid = 1'b0;
    check(op <= 9 ? "R3" : reqOf(op), flags, fl);
  endtask

  initial begin
    rstN = 1'b0; opValid = 0; opCode = 0; accIn = 0; operand = 0;
    hlIn = 0; pairIn = 0; flagWrEn = 0; flagWrData = 0;
    repeat (3) @(negedge clk);
    check("R9", flags, 8'h02);
    rstN = 1'b1;
    @(negedge clk);
    check("R12", resultWe, 0);
    check("R9", flags, 8'h02);

    // R9: constant bits under all-ones / all-zero writes
    runVec(15, 0, 0, 0, 0, 8'hFF);
    runVec(13, 0, 0, 0, 0, 8'h00);

    // binary arithmetic and logic sweep, both carry states (R1, R2, R4, R5)
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a += 3)
        for (int b = 0; b < 256; b += 11)
          for (int c = 0; c < 2; c++)
            runVec(op, a, b, 0, 0, ((a * 7 + b) & 8'hFE) | c);

    // boundaries
    runVec(0, 255, 1, 0, 0, 0);
    runVec(0, 15, 1, 0, 0, 0);
    runVec(1, 255, 0, 0, 0, 1);
    runVec(2, 0, 1, 0, 0, 0);
    runVec(3, 0, 0, 0, 0, 1);
    runVec(3, 16, 0, 0, 0, 1);
    runVec(7, 42, 42, 0, 0, 1);

    // increment / decrement full operand range (R6)
    for (int b = 0; b < 256; b++)
      for (int c = 0; c < 2; c++) begin
        runVec(8, 8'h5A, b, 0, 0, (b & 8'hFE) | c);
        runVec(9, 8'hA5, b, 0, 0, ((b * 3) & 8'hFE) | c);
      end

    // carry-only operations (R7)
    for (int p = 0; p < 256; p += 5) begin
      runVec(10, 0, 0, 0, 0, p);
      runVec(11, 0, 0, 0, 0, p);
    end

    // wide add (R8), incl. self-add = shift left
    for (int h = 0; h < 65536; h += 4099)
      for (int q = 0; q < 65536; q += 5003)
        runVec(12, 0, 0, h, q, (h ^ q) & 8'hFF);
    runVec(12, 0, 0, 16'hFFFF, 1, 8'h00);
    runVec(12, 0, 0, 16'h8001, 16'h8001, 8'hD4);
    runVec(12, 0, 0, 16'h1234, 16'h1234, 8'hD5);

    // unassigned opcodes (R12)
    for (int op = 13; op < 16; op++) runVec(op, 8'hFF, 8'hFF, 0, 0, 8'h41);

    // same-cycle group write and add (R10): write wins, add uses old carry
    flagWrEn = 1'b1; flagWrData = 8'h01; opValid = 1'b0;
    @(negedge clk);
    flagWrData = 8'h40; opValid = 1'b1; opCode = 4'd1;
    accIn = 8'hFF; operand = 8'h00;
    #2;
    check("R10", result, 8'h00);
    check("R10", resultWe, 1);
    @(negedge clk);
    flagWrEn = 1'b0; opValid = 1'b0;
    check("R10", flags, 8'h42);
    @(negedge clk);
    check("R12", flags, 8'h42);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule